// File: doc/BRIEF.md
# Register-Mapped Watchdog Countdown Timer

This block is a system watchdog. A prescaler divides the system clock into coarse ticks (one tick represents 0.6 s of wall time, so a timeout in seconds is converted to ticks as seconds × 10 / 6). A down-counter steps once per tick. Software must restart the count before it runs out, and it does so by writing any value to the reload location. When the counter expires, the block latches a timeout status flag, reloads itself and carries on. It can also emit a one-cycle reset request and a one-cycle system-management interrupt request.

Software reaches the block through a small byte-addressed register file on a single-cycle synchronous write bus with combinational read data. The registers hold the initial count, a halt control, the status flags, a reboot veto flag and an interrupt enable. A hardware strap input can lock the reboot veto on. After software writes the veto to zero, it reads the flag back to find out whether the strap has overridden it. A build parameter selects a narrow legacy layout: a 6-bit initial-value field at offset 0x01 in place of the 10-bit field at offset 0x12.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register (0x08) reads 0x0800, meaning halted. The veto register (0x0C) reads 1. The initial-value register (0x12) reads 50. The count (0x00) reads 50. Both status registers (0x04, 0x06) read 0. The interrupt-enable register (0x10) reads 0x2000. Both request outputs are low.
- R2: A write of any data to offset 0x00 loads the counter from the initial-value field and restarts the tick prescaler.
- R3: While bit 11 of 0x08 is 0, the count read at 0x00 falls by one every TICK_CYCLES clock cycles.
- R4: While bit 11 of 0x08 is 1, the count does not change.
- R5: A write to 0x12 whose low 10 bits are 0 to 3 leaves the register unchanged. Any other write updates only the low 10 bits. Bits 15:10 always read 0.
- R6: If a tick arrives while the count is 0, the counter reloads from the initial value and bit 3 of 0x04 is set. With a reload at clock edge P and initial value N, this happens at edge P + (N+1)·TICK_CYCLES.
- R7: When the counter expires, `rstReq` is high for exactly one cycle, but only if the veto flag reads 0.
- R8: Bit 0 of 0x0C is the reboot veto and can be read and written. While `rebootLock` is high it reads 1 whatever was written, and it suppresses `rstReq`.
- R9: Bit 3 of 0x04 and bit 1 of 0x06 are write-one-to-clear, and writing 0 to them has no effect. Bit 1 of 0x06 is set when the counter expires while bit 3 of 0x04 is already set.
- R10: Bit 13 of 0x10 resets to 1 and can be written. When the counter expires, `smiReq` pulses for one cycle only while this bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, sampled at the rising edge |
| addr | input | 8 | Byte offset of the register accessed |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for `addr` |
| rebootLock | input | 1 | Hardware strap that forces the reboot veto on |
| rstReq | output | 1 | One-cycle reset request on expiry |
| smiReq | output | 1 | One-cycle interrupt request on expiry |

## Verification
A fault in the prescaler or the counter appears at offset 0x00 within one tick period as a count that is off by one or that holds when it should move. The bench therefore compares the count against a tick-exact model at random points in the countdown. A fault in the reset gating or the pulse shaping appears on `rstReq` or `smiReq` at the exact expiry edge, so the bench samples those outputs on the cycle before that edge, on the edge itself and on the cycle after it. A sticky status bit that clears wrongly, or an illegal initial value that gets through, appears at the next register read.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFS_RELOAD      = 8'h00;
  localparam logic [7:0] OFS_INIT_NARROW = 8'h01;
  localparam logic [7:0] OFS_STAT_A      = 8'h04;
  localparam logic [7:0] OFS_STAT_B      = 8'h06;
  localparam logic [7:0] OFS_CTRL        = 8'h08;
  localparam logic [7:0] OFS_VETO        = 8'h0C;
  localparam logic [7:0] OFS_SMI         = 8'h10;
  localparam logic [7:0] OFS_INIT_WIDE   = 8'h12;

  localparam int HALT_BIT   = 11;
  localparam int TMO_BIT    = 3;
  localparam int SECOND_BIT = 1;
  localparam int SMIEN_BIT  = 13;
  localparam int VETO_BIT   = 0;
  localparam int MIN_INIT   = 4;

  typedef struct packed {
    logic reload;
    logic run;
  } wdogStrobe_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int TICK_CYCLES = 75000000,
  parameter int DEF_INIT    = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdogStrobe_t      strobe,
  input  logic [CNT_W-1:0] initVal,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic tick;

  generate
    if (TICK_CYCLES > 1) begin : g_prescale
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN)               preCnt <= '0;
        else if (strobe.reload)  preCnt <= '0;
        else if (strobe.run)     preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
      end
      assign tick = strobe.run && (preCnt == PRE_LAST);
    end else begin : g_direct
      assign tick = strobe.run;
    end
  endgenerate

  assign expire = tick && (count == '0) && !strobe.reload;

  always_ff @(posedge clk) begin
    if (!rstN)               count <= CNT_W'(DEF_INIT);
    else if (strobe.reload)  count <= initVal;
    else if (tick) begin
      if (count == '0)       count <= initVal;
      else                   count <= count - 1'b1;
    end
  end

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.reload) |=> $stable(count)); // R4

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (tick && count != '0 && !strobe.reload) |=> (count == $past(count) - 1'b1)); // R3

  AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (count == $past(initVal))); // R6

  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (count == $past(initVal))); // R2
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int         CNT_W    = 10,
  parameter logic [7:0] INIT_OFS = 8'h12,
  parameter int         DEF_INIT = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       addr,
  input  logic [15:0]      wrData,
  output logic [15:0]      rdData,
  input  logic             rebootLock,
  input  logic             expire,
  input  logic [CNT_W-1:0] count,
  output wdogStrobe_t      strobe,
  output logic [CNT_W-1:0] initVal,
  output logic             rstReq,
  output logic             smiReq
);
  logic haltBit, vetoFlag, smiEn, tmoFlag, secondFlag;
  logic vetoRd;
  logic wrInit, wrCtrl, wrVeto, wrSmi, wrStatA, wrStatB;
  logic [CNT_W-1:0] initField;
  logic initLegal;

  assign wrInit  = wrEn && (addr == INIT_OFS);
  assign wrCtrl  = wrEn && (addr == OFS_CTRL);
  assign wrVeto  = wrEn && (addr == OFS_VETO);
  assign wrSmi   = wrEn && (addr == OFS_SMI);
  assign wrStatA = wrEn && (addr == OFS_STAT_A);
  assign wrStatB = wrEn && (addr == OFS_STAT_B);

  assign initLegal = wrData[CNT_W-1:0] >= CNT_W'(MIN_INIT);
  assign vetoRd    = vetoFlag || rebootLock;

  assign strobe.reload = wrEn && (addr == OFS_RELOAD);
  assign strobe.run    = !haltBit;
  assign initVal       = initField;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initField  <= CNT_W'(DEF_INIT);
      haltBit    <= 1'b1;
      vetoFlag   <= 1'b1;
      smiEn      <= 1'b1;
      tmoFlag    <= 1'b0;
      secondFlag <= 1'b0;
      rstReq     <= 1'b0;
      smiReq     <= 1'b0;
    end else begin
      if (wrInit && initLegal) initField <= wrData[CNT_W-1:0];
      if (wrCtrl) haltBit  <= wrData[HALT_BIT];
      if (wrVeto) vetoFlag <= wrData[VETO_BIT];
      if (wrSmi)  smiEn    <= wrData[SMIEN_BIT];

      if (expire)                            tmoFlag <= 1'b1;
      else if (wrStatA && wrData[TMO_BIT])   tmoFlag <= 1'b0;

      if (expire && tmoFlag)                  secondFlag <= 1'b1;
      else if (wrStatB && wrData[SECOND_BIT]) secondFlag <= 1'b0;

      rstReq <= expire && !vetoRd;
      smiReq <= expire && smiEn;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == OFS_RELOAD)      rdData = 16'(count);
    else if (addr == INIT_OFS)   rdData = 16'(initField);
    else if (addr == OFS_CTRL)   rdData[HALT_BIT]   = haltBit;
    else if (addr == OFS_VETO)   rdData[VETO_BIT]   = vetoRd;
    else if (addr == OFS_SMI)    rdData[SMIEN_BIT]  = smiEn;
    else if (addr == OFS_STAT_A) rdData[TMO_BIT]    = tmoFlag;
    else if (addr == OFS_STAT_B) rdData[SECOND_BIT] = secondFlag;
  end

  AST_INIT_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (wrInit && !initLegal) |=> $stable(initField)); // R5

  AST_RST_GATED: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> !$past(vetoRd)); // R7

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq); // R7

  AST_TMO_SET: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> tmoFlag); // R6

  AST_SMI_GATED: assert property (@(posedge clk) disable iff (!rstN)
    smiReq |-> $past(smiEn)); // R10
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int TICK_CYCLES = 75000000,
  parameter bit LEGACY      = 1'b0,
  parameter int DEF_INIT    = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        rebootLock,
  output logic        rstReq,
  output logic        smiReq
);
  localparam int         CNT_W    = LEGACY ? 6 : 10;
  localparam logic [7:0] INIT_OFS = LEGACY ? OFS_INIT_NARROW : OFS_INIT_WIDE;

  wdogStrobe_t      strobe;
  logic [CNT_W-1:0] initVal;
  logic [CNT_W-1:0] count;
  logic             expire;

  wdog_regs #(.CNT_W(CNT_W), .INIT_OFS(INIT_OFS), .DEF_INIT(DEF_INIT)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rebootLock(rebootLock), .expire(expire), .count(count),
    .strobe(strobe), .initVal(initVal), .rstReq(rstReq), .smiReq(smiReq)
  );

  wdog_datapath #(.CNT_W(CNT_W), .TICK_CYCLES(TICK_CYCLES), .DEF_INIT(DEF_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .initVal(initVal),
    .count(count), .expire(expire)
  );
endmodule

// File: tb/wdog_timer_test.sv
`timescale 1ns/1ps
module wdog_timer_test;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [15:0] wrData = 16'h0000;
  logic rebootLock = 1'b0;
  logic [15:0] rdData;
  logic rstReq, smiReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  wdog_timer #(.TICK_CYCLES(T)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rebootLock(rebootLock), .rstReq(rstReq), .smiReq(smiReq)
  );

  function automatic logic [15:0] initModel(input logic [15:0] prev, input logic [15:0] d);
    if (d[9:0] >= 10'd4) return {6'd0, d[9:0]};
    return prev;
  endfunction

  function automatic int countModel(input int n, input int cyc);
    return n - cyc / T;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [15:0] initExp;
    logic [15:0] held;
    void'($urandom(32'h5EED_0042));

    wait_cyc(3);
    rstN = 1'b1;
    wait_cyc(1);

    // R1 reset state
    rd(8'h08, v); chk("R1 ctrl", v, 16'h0800);
    rd(8'h0C, v); chk("R1 veto", v, 16'h0001);
    rd(8'h12, v); chk("R1 init", v, 16'd50);
    rd(8'h00, v); chk("R1 count", v, 16'd50);
    rd(8'h04, v); chk("R1 statA", v, 16'h0000);
    rd(8'h06, v); chk("R1 statB", v, 16'h0000);
    rd(8'h10, v); chk("R1 smi", v, 16'h2000);
    chk("R1 rstReq", {15'd0, rstReq}, 16'd0);

    // R4 halted after reset
    wait_cyc(40);
    rd(8'h00, v); chk("R4 halted count", v, 16'd50);

    // R5 directed and random initial-value writes
    initExp = 16'd50;
    wr(8'h12, 16'h0003); initExp = initModel(initExp, 16'h0003);
    rd(8'h12, v); chk("R5 illegal 3", v, initExp);
    wr(8'h12, 16'hFC07); initExp = initModel(initExp, 16'hFC07);
    rd(8'h12, v); chk("R5 upper bits", v, initExp);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if (i % 4 == 0) d[9:0] = 10'($urandom % 4);
      wr(8'h12, d);
      initExp = initModel(initExp, d);
      rd(8'h12, v); chk("R5 random init", v, initExp);
    end

    // R2 R3 running countdown at random sample points
    wr(8'h08, 16'h0000);
    for (int i = 0; i < 12; i++) begin
      int n, m;
      n = 4 + int'($urandom % 17);
      m = int'($urandom % (n * T));
      wr(8'h12, 16'(n));
      wr(8'h00, 16'($urandom));
      rd(8'h00, v); chk("R2 reload value", v, 16'(n));
      wait_cyc(m);
      rd(8'h00, v); chk("R3 countdown", v, 16'(countModel(n, m)));
    end

    // R4 halt mid-count
    wr(8'h12, 16'd20);
    wr(8'h00, 16'hBEEF);
    wait_cyc(9);
    wr(8'h08, 16'h0800);
    rd(8'h00, held);
    wait_cyc(25);
    rd(8'h00, v); chk("R4 halt freeze", v, held);

    // R6 R7 R10 expiry with reboot allowed
    wr(8'h04, 16'h0008);
    wr(8'h06, 16'h0002);
    wr(8'h0C, 16'h0000);
    rd(8'h0C, v); chk("R8 veto cleared", v, 16'h0000);
    wr(8'h12, 16'd4);
    wr(8'h08, 16'h0000);
    wr(8'h00, 16'h0000);
    wait_cyc(19);
    chk("R7 no early rstReq", {15'd0, rstReq}, 16'd0);
    chk("R10 no early smiReq", {15'd0, smiReq}, 16'd0);
    rd(8'h04, v); chk("R6 no early status", v, 16'h0000);
    wait_cyc(1);
    chk("R7 rstReq at expiry", {15'd0, rstReq}, 16'd1);
    chk("R10 smiReq at expiry", {15'd0, smiReq}, 16'd1);
    rd(8'h04, v); chk("R6 status set", v, 16'h0008);
    rd(8'h00, v); chk("R6 reloaded", v, 16'd4);
    wait_cyc(1);
    chk("R7 one-cycle pulse", {15'd0, rstReq}, 16'd0);
    wait_cyc(19);
    rd(8'h06, v); chk("R9 second expiry", v, 16'h0002);
    chk("R7 second pulse", {15'd0, rstReq}, 16'd1);

    // R9 write-one-to-clear
    wr(8'h04, 16'hFFF7);
    rd(8'h04, v); chk("R9 write zero keeps", v, 16'h0008);
    wr(8'h04, 16'h0008);
    rd(8'h04, v); chk("R9 w1c statA", v, 16'h0000);
    wr(8'h06, 16'h0002);
    rd(8'h06, v); chk("R9 w1c statB", v, 16'h0000);

    // R10 interrupt disabled
    wr(8'h10, 16'h0000);
    rd(8'h10, v); chk("R10 smi cleared", v, 16'h0000);
    wr(8'h00, 16'h0000);
    wait_cyc(20);
    chk("R10 smiReq off", {15'd0, smiReq}, 16'd0);
    chk("R7 rstReq still fires", {15'd0, rstReq}, 16'd1);

    // R8 strap lock
    wr(8'h04, 16'h0008);
    rebootLock = 1'b1;
    rd(8'h0C, v); chk("R8 lock reads 1", v, 16'h0001);
    wr(8'h0C, 16'h0000);
    rd(8'h0C, v); chk("R8 clear under lock", v, 16'h0001);
    wr(8'h00, 16'h0000);
    wait_cyc(20);
    chk("R8 rstReq suppressed", {15'd0, rstReq}, 16'd0);
    rd(8'h04, v); chk("R6 status under lock", v, 16'h0008);
    rebootLock = 1'b0;
    rd(8'h0C, v); chk("R8 lock released", v, 16'h0000);

    finish_run();
  end
endmodule